// File: doc/BRIEF.md
# 100BASE-TX Receive Symbol Decoder

This block sits behind the code-group aligner and descrambler of a 100 Mb/s twisted-pair receiver. Each cycle that its strobe is high, it takes one 5-bit code group and updates a registered 4-bit receive nibble and three indications: carrier present, data valid and receive error. It also keeps a count of damaged packets that software can read. A small framing state machine follows the stream delimiters. It reports a frame only after a complete start delimiter, ends the frame only on a proper end delimiter, and flags every code group that does not belong inside a frame.

The state machine has four states:
- `S_IDLE`: no carrier.
- `S_SSD2`: the first start symbol has been seen and the second is awaited.
- `S_FRAME`: inside a frame.
- `S_END`: the first end symbol has been seen and the second is awaited.

It has these transitions:
- `S_IDLE`→`S_SSD2` on the first start symbol.
- `S_SSD2`→`S_FRAME` on the second start symbol.
- `S_SSD2`→`S_IDLE` on any other symbol.
- `S_FRAME`→`S_END` on the first end symbol.
- `S_END`→`S_IDLE` on the second end symbol.
- `S_END`→`S_FRAME` on any other symbol, which is flagged as an error.
- Any state →`S_IDLE` while the link is down.

Top module: `rx_symbol_decoder`

## Requirements
- R1: After reset, `rx_dv_o`, `rx_er_o` and `crs_o` are low, `rxd_o` is 0000 and `err_count_o` is 0.
- R2: Inside a frame, each data code group yields `rx_dv_o`=1, `rx_er_o`=0 and its nibble one cycle later. The mapping is 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R3: A start symbol 11000 out of a frame raises `crs_o` with `rxd_o`=0101 and `rx_dv_o` low. If 10001 follows at once, the same outputs are kept and the frame opens. Any other follower returns all outputs low. `rx_dv_o` first rises with the first data nibble.
- R4: In a frame, 01101 gives `crs_o`=1, `rx_dv_o`=0, `rxd_o`=0000. If the next code group is 00111, all outputs go low and the frame closes. Any other next code group gives `rx_dv_o`=1, `rx_er_o`=1, and the frame continues.
- R5: An 00111 inside a frame that does not directly follow 01101 gives `rx_er_o`=1 and `rx_dv_o`=1, and the frame stays open.
- R6: 00100 inside a frame gives `rx_er_o`=1, `rx_dv_o`=1, `rxd_o`=0000.
- R7: 00110 and 11001 inside a frame give `rx_er_o`=1, `rx_dv_o`=1, `rxd_o`=0000.
- R8: `err_count_o` goes up by one on the first symbol of a packet that raises `rx_er_o`. Further errors before the next start symbol leave it unchanged.
- R9: `err_count_o` (CNT_W bits, 16 by default) stops at all-ones.
- R10: A one-cycle `cnt_rd_i` pulse clears `err_count_o` on the next edge. If an error is counted in that same cycle, the result is 1.
- R11: Out of a frame, idle 11111 and any code group other than 11000 keep all three indications low and leave `err_count_o` unchanged.
- R12: While `link_up_i` is low, the outputs are driven low and the frame is dropped. A data code group after the link returns produces no output.
- R13: In a cycle with `sym_valid_i` low, every output and the framing state hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_i | input | 5 | Aligned, descrambled code group |
| sym_valid_i | input | 1 | `sym_i` carries a new code group this cycle |
| link_up_i | input | 1 | Receive link established |
| cnt_rd_i | input | 1 | Read strobe, clears the error count |
| rxd_o | output | 4 | Receive nibble |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| crs_o | output | 1 | Carrier sense |
| err_count_o | output | CNT_W | Count of packets holding at least one error symbol |

## Verification
The bench targets the end-delimiter pairing:
- A decoder that closes on any 00111 would drop carrier in the middle of the error frame.
- A decoder that closes on 01101 alone would miss the error on the symbol that follows it.

It sends several bad symbols in one packet. A counter that counts every bad symbol, rather than one per packet, would show a value above 1. It also checks:
- saturation and the read-while-counting collision, where a wrapping or read-losing counter shows 0;
- a start symbol that is not followed by the second one, where a lax decoder would open a frame;
- a dropped link, where a decoder that leaves the frame open would decode the next data symbol.

// File: rtl/rx_sym_pkg.sv
package rx_sym_pkg;

    typedef enum logic [2:0] {
        SC_DATA, SC_IDLE, SC_SSD1, SC_SSD2, SC_ESD1, SC_ESD2, SC_HALT, SC_BAD
    } sym_class_e;

    typedef struct packed {
        sym_class_e cls;
        logic [3:0] nib;
    } sym_info_t;

    typedef enum logic [1:0] {
        S_IDLE, S_SSD2, S_FRAME, S_END
    } rx_state_e;

    localparam logic [3:0] PREAMBLE_NIB = 4'b0101;

    function automatic sym_info_t classify(input logic [4:0] s);
        sym_info_t r;
        r.cls = SC_DATA;
        r.nib = 4'h0;
        unique case (s)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            5'b11111: r.cls = SC_IDLE;
            5'b11000: r.cls = SC_SSD1;
            5'b10001: r.cls = SC_SSD2;
            5'b01101: r.cls = SC_ESD1;
            5'b00111: r.cls = SC_ESD2;
            5'b00100: r.cls = SC_HALT;
            default:  r.cls = SC_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rx_sym_classify.sv
module rx_sym_classify
    import rx_sym_pkg::*;
(
    input  logic [4:0] sym_i,
    output sym_info_t  info_o
);
    always_comb begin
        info_o = classify(sym_i);
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_sym_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid_i,
    input  logic       link_up_i,
    input  sym_info_t  info_i,
    output logic [3:0] rxd_o,
    output logic       rx_dv_o,
    output logic       rx_er_o,
    output logic       crs_o,
    output logic       err_first_o
);
    rx_state_e  st_q, st_n;
    logic [3:0] rxd_q, rxd_n;
    logic       dv_q, dv_n, er_q, er_n, crs_q, crs_n;
    logic       seen_q, seen_n;
    logic       hit_err;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            seen_q <= seen_n;
        end
    end

    // next state and next outputs
    always_comb begin
        st_n    = st_q;
        seen_n  = seen_q;
        rxd_n   = rxd_q;
        dv_n    = dv_q;
        er_n    = er_q;
        crs_n   = crs_q;
        hit_err = 1'b0;
        err_first_o = 1'b0;
        if (!link_up_i) begin
            st_n   = S_IDLE;
            seen_n = 1'b0;
            rxd_n  = 4'h0;
            dv_n   = 1'b0;
            er_n   = 1'b0;
            crs_n  = 1'b0;
        end else if (sym_valid_i) begin
            rxd_n = 4'h0;
            dv_n  = 1'b0;
            er_n  = 1'b0;
            crs_n = 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (info_i.cls == SC_SSD1) begin
                        st_n   = S_SSD2;
                        seen_n = 1'b0;
                        crs_n  = 1'b1;
                        rxd_n  = PREAMBLE_NIB;
                    end
                end
                S_SSD2: begin
                    if (info_i.cls == SC_SSD2) begin
                        st_n  = S_FRAME;
                        crs_n = 1'b1;
                        rxd_n = PREAMBLE_NIB;
                    end else begin
                        st_n = S_IDLE;
                    end
                end
                S_FRAME: begin
                    crs_n = 1'b1;
                    if (info_i.cls == SC_DATA) begin
                        dv_n  = 1'b1;
                        rxd_n = info_i.nib;
                    end else if (info_i.cls == SC_ESD1) begin
                        st_n = S_END;
                    end else begin
                        dv_n    = 1'b1;
                        hit_err = 1'b1;
                    end
                end
                S_END: begin
                    if (info_i.cls == SC_ESD2) begin
                        st_n = S_IDLE;
                    end else begin
                        st_n    = S_FRAME;
                        crs_n   = 1'b1;
                        dv_n    = 1'b1;
                        hit_err = 1'b1;
                    end
                end
                default: st_n = S_IDLE;
            endcase
            if (hit_err) begin
                er_n        = 1'b1;
                err_first_o = !seen_q;
                seen_n      = 1'b1;
            end
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_q <= 4'h0;
            dv_q  <= 1'b0;
            er_q  <= 1'b0;
            crs_q <= 1'b0;
        end else begin
            rxd_q <= rxd_n;
            dv_q  <= dv_n;
            er_q  <= er_n;
            crs_q <= crs_n;
        end
    end

    assign rxd_o   = rxd_q;
    assign rx_dv_o = dv_q;
    assign rx_er_o = er_q;
    assign crs_o   = crs_q;
endmodule

// File: rtl/rx_err_counter.sv
module rx_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    input  logic             rd_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rd_i) begin
            cnt_q <= bump_i ? CNT_ONE : '0;
        end else if (bump_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/rx_symbol_decoder.sv
module rx_symbol_decoder
    import rx_sym_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       sym_i,
    input  logic             sym_valid_i,
    input  logic             link_up_i,
    input  logic             cnt_rd_i,
    output logic [3:0]       rxd_o,
    output logic             rx_dv_o,
    output logic             rx_er_o,
    output logic             crs_o,
    output logic [CNT_W-1:0] err_count_o
);
    sym_info_t info;
    logic      err_first;

    rx_sym_classify u_classify (
        .sym_i  (sym_i),
        .info_o (info)
    );

    rx_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid_i (sym_valid_i),
        .link_up_i   (link_up_i),
        .info_i      (info),
        .rxd_o       (rxd_o),
        .rx_dv_o     (rx_dv_o),
        .rx_er_o     (rx_er_o),
        .crs_o       (crs_o),
        .err_first_o (err_first)
    );

    rx_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump_i  (err_first),
        .rd_i    (cnt_rd_i),
        .count_o (err_count_o)
    );
endmodule

// File: rtl/rx_symbol_decoder_chk.sv
module rx_symbol_decoder_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid_i,
    input logic             link_up_i,
    input logic             cnt_rd_i,
    input logic [3:0]       rxd_o,
    input logic             rx_dv_o,
    input logic             rx_er_o,
    input logic             crs_o,
    input logic [CNT_W-1:0] err_count_o
);
    // R2
    dv_needs_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv_o |-> crs_o);

    // R5
    er_needs_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er_o |-> rx_dv_o);

    // R3
    carrier_opens_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs_o) |-> (rxd_o == 4'b0101 && !rx_dv_o));

    // R12
    link_down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up_i |=> (!crs_o && !rx_dv_o && !rx_er_o));

    // R13
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_i && !sym_valid_i) |=> ($stable(rxd_o) && $stable(rx_dv_o) && $stable(rx_er_o) && $stable(crs_o)));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rd_i |=> (err_count_o >= $past(err_count_o) && (err_count_o - $past(err_count_o)) <= 1));

    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd_i |=> (err_count_o <= 1));
endmodule

bind rx_symbol_decoder rx_symbol_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid_i (sym_valid_i),
    .link_up_i   (link_up_i),
    .cnt_rd_i    (cnt_rd_i),
    .rxd_o       (rxd_o),
    .rx_dv_o     (rx_dv_o),
    .rx_er_o     (rx_er_o),
    .crs_o       (crs_o),
    .err_count_o (err_count_o)
);

// File: tb/rx_symbol_decoder_test.sv
`timescale 1ns/1ps
module rx_symbol_decoder_test;
    localparam int CW = 4;
    localparam int NV = 42;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    sym = 5'b11111;
    logic          sym_valid = 1'b0;
    logic          link_up = 1'b1;
    logic          cnt_rd = 1'b0;
    logic [3:0]    rxd;
    logic          rx_dv, rx_er, crs;
    logic [CW-1:0] cnt;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rx_symbol_decoder #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .sym_i(sym), .sym_valid_i(sym_valid),
        .link_up_i(link_up), .cnt_rd_i(cnt_rd), .rxd_o(rxd), .rx_dv_o(rx_dv),
        .rx_er_o(rx_er), .crs_o(crs), .err_count_o(cnt)
    );

    // {symbol, dv, er, crs, rxd}
    localparam logic [11:0] VEC [NV] = '{
        {5'b11111, 3'b000, 4'h0}, {5'b11000, 3'b001, 4'h5}, {5'b10001, 3'b001, 4'h5},
        {5'b11110, 3'b101, 4'h0}, {5'b01001, 3'b101, 4'h1}, {5'b10100, 3'b101, 4'h2},
        {5'b10101, 3'b101, 4'h3}, {5'b01010, 3'b101, 4'h4}, {5'b01011, 3'b101, 4'h5},
        {5'b01110, 3'b101, 4'h6}, {5'b01111, 3'b101, 4'h7}, {5'b10010, 3'b101, 4'h8},
        {5'b10011, 3'b101, 4'h9}, {5'b10110, 3'b101, 4'hA}, {5'b10111, 3'b101, 4'hB},
        {5'b11010, 3'b101, 4'hC}, {5'b11011, 3'b101, 4'hD}, {5'b11100, 3'b101, 4'hE},
        {5'b11101, 3'b101, 4'hF}, {5'b01101, 3'b001, 4'h0}, {5'b00111, 3'b000, 4'h0},
        {5'b11111, 3'b000, 4'h0}, {5'b00110, 3'b000, 4'h0}, {5'b11000, 3'b001, 4'h5},
        {5'b01001, 3'b000, 4'h0}, {5'b11000, 3'b001, 4'h5}, {5'b10001, 3'b001, 4'h5},
        {5'b01011, 3'b101, 4'h5}, {5'b00100, 3'b111, 4'h0}, {5'b00111, 3'b111, 4'h0},
        {5'b00110, 3'b111, 4'h0}, {5'b11001, 3'b111, 4'h0}, {5'b10110, 3'b101, 4'hA},
        {5'b01101, 3'b001, 4'h0}, {5'b10101, 3'b111, 4'h0}, {5'b10101, 3'b101, 4'h3},
        {5'b01101, 3'b001, 4'h0}, {5'b00111, 3'b000, 4'h0}, {5'b11111, 3'b000, 4'h0},
        {5'b11001, 3'b000, 4'h0}, {5'b00100, 3'b000, 4'h0}, {5'b11111, 3'b000, 4'h0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [6:0] exp);
        check(req, {rx_dv, rx_er, crs, rxd}, exp);
    endtask

    // drive one cycle at a falling edge, leave at the next falling edge
    task automatic step(input logic [4:0] s, input logic v);
        sym = s;
        sym_valid = v;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic send_bad_packet();
        step(5'b11000, 1'b1);
        step(5'b10001, 1'b1);
        step(5'b00110, 1'b1);
        step(5'b01101, 1'b1);
        step(5'b00111, 1'b1);
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_out("R1 outputs", 7'h00);
        check("R1 count", int'(cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R7 R11 table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11:7], 1'b1);
            check_out($sformatf("R2-table vec %0d (R3/R4/R5/R6/R7/R11)", i), VEC[i][6:0]);
        end
        // R8 one count for the packet with many errors, none from out-of-frame junk
        check("R8 count once per packet", int'(cnt), 1);

        // R10 read clears
        cnt_rd = 1'b1;
        step(5'b11111, 1'b0);
        cnt_rd = 1'b0;
        check("R10 read clears", int'(cnt), 0);

        // R13 hold while strobe low
        step(5'b11000, 1'b1);
        step(5'b10001, 1'b1);
        step(5'b01111, 1'b1);
        step(5'b00110, 1'b0);
        check_out("R13 hold", 7'h57);
        check("R13 count untouched", int'(cnt), 0);

        // R12 link drop closes the frame
        link_up = 1'b0;
        step(5'b01111, 1'b1);
        check_out("R12 link down", 7'h00);
        link_up = 1'b1;
        step(5'b01111, 1'b1);
        check_out("R12 no frame after link returns", 7'h00);

        // R9 saturation at all-ones
        for (int p = 0; p < 15; p++) send_bad_packet();
        check("R9 reach max", int'(cnt), 15);
        send_bad_packet();
        check("R9 saturate", int'(cnt), 15);

        // R10 read colliding with a counted error
        step(5'b11000, 1'b1);
        step(5'b10001, 1'b1);
        cnt_rd = 1'b1;
        step(5'b11001, 1'b1);
        cnt_rd = 1'b0;
        check("R10 read with bump", int'(cnt), 1);
        check_out("R7 11001 in frame", 7'h70);
        step(5'b01101, 1'b1);
        step(5'b00111, 1'b1);
        check_out("R4 close", 7'h00);

        finished = 1;
        report();
        $finish;
    end
endmodule